// File: doc/BRIEF.md
# Segmented Insert/Delete Shift Memory

This block is a word-wide storage array split into equal segments, each of which acts as a shift track. Besides plain reads and writes it supports positional insertion, where everything on one side of the target slot slides one place to make room, and positional deletion, where the target entry disappears and its neighbours slide back to close the gap. The caller picks which way the slide runs, toward the tail (higher indices) or toward the head (lower indices).

A vector of boundary links can join neighbouring segments into one longer logical track. A request names a starting segment and an offset. The logical track runs from that segment through every following segment whose boundary link is set. An entry pushed past the end of one segment moves into the first slot of the next linked segment, and an entry pushed past the end of the logical track is lost. A deletion pulls entries across linked boundaries the same way and puts zero into the vacated end slot. Segments outside the logical track are never touched.

Every request is completed in the cycle it is sampled. The result, a done pulse plus read data or an error flag, appears one cycle later.

Top module: `smem_relay_track`

## Requirements
- R1: After reset every entry reads as zero, and `rsp_done` and `rsp_err` are low.
- R2: Operation code 0 is a read. One cycle after the request, `rsp_data` holds the entry at the addressed slot, and no entry changes.
- R3: Operation code 1 is a write. It replaces only the addressed entry with `req_data`.
- R4: Operation code 2 with `req_dir`=0 is an insert toward the tail. Entries from the target to the span end move up one slot, the last entry of the span is dropped, and `req_data` lands at the target.
- R5: Operation code 2 with `req_dir`=1 is an insert toward the head. Entries from the span start up to the target move down one slot, the first entry of the span is dropped, and `req_data` lands at the target.
- R6: Operation code 3 with `req_dir`=0 is a delete toward the tail. The target is removed, entries above it move down one slot, and the last slot of the span becomes zero.
- R7: Operation code 3 with `req_dir`=1 is a delete toward the head. The target is removed, entries below it move up one slot, and the first slot of the span becomes zero.
- R8: Bit k of `link_en` joins segment k to segment k+1. The span starts at segment `req_seg` at flat slot `req_seg*SEG_LEN` and runs through each following segment while its link bit is set. `req_pos` is an offset from the span start, and shifted entries cross linked boundaries.
- R9: Slots outside the span keep their value. In particular, the neighbour behind an unset link never receives the entry shifted off the span end.
- R10: When `req_pos` is at or beyond the span length, the request is rejected. No entry changes, and `rsp_err` and `rsp_done` are high with `rsp_data` zero.
- R11: Each request yields exactly one `rsp_done` pulse, one cycle after it is sampled. `rsp_data` is zero for every operation other than a read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request strobe, one request per cycle |
| req_op | input | 2 | 0 read, 1 write, 2 insert, 3 delete |
| req_dir | input | 1 | Slide direction: 0 toward tail, 1 toward head |
| req_seg | input | SEG_W | First segment of the logical track |
| req_pos | input | POS_W | Offset within the logical track |
| req_data | input | DATA_W | Value for write or insert |
| link_en | input | LINK_W | Boundary links, bit k joins segment k to k+1 |
| rsp_done | output | 1 | One-cycle completion pulse |
| rsp_err | output | 1 | Offset out of span |
| rsp_data | output | DATA_W | Read result |

## Verification
Directed inserts and deletes in both directions are aimed at the slots next to segment boundaries. Each one is run once with the link set and once with it clear, and a full read-back afterwards shows whether the boundary entry was carried over or dropped. Offsets just beyond a single segment, beyond a two-segment span, and in the last segment separate the error path from a shift that wraps or truncates. A long seeded random mix of link vectors, start segments, offsets and operations is checked against a reference array with periodic full read-backs. This catches any wrong span length or any stray write outside the span.

// File: rtl/smem_pkg.sv
package smem_pkg;
    typedef enum logic [1:0] {
        OP_READ   = 2'd0,
        OP_WRITE  = 2'd1,
        OP_INSERT = 2'd2,
        OP_DELETE = 2'd3
    } op_e;
endpackage

// File: rtl/smem_span.sv
module smem_span #(
    parameter int NUM_SEG = 4,
    parameter int SEG_LEN = 8,
    parameter int TOTAL   = NUM_SEG * SEG_LEN,
    parameter int POS_W   = (TOTAL > 1) ? $clog2(TOTAL) : 1,
    parameter int SEG_W   = (NUM_SEG > 1) ? $clog2(NUM_SEG) : 1,
    parameter int LINK_W  = (NUM_SEG > 1) ? NUM_SEG - 1 : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [SEG_W-1:0]  req_seg,
    input  logic [POS_W-1:0]  req_pos,
    input  logic [LINK_W-1:0] link_en,
    output logic [POS_W-1:0]  span_lo,
    output logic [POS_W-1:0]  span_hi,
    output logic [POS_W-1:0]  abs_pos,
    output logic              pos_err
);
    always_comb begin
        int   cnt;
        int   lo;
        logic run;
        cnt = 1;
        run = 1'b1;
        for (int k = 0; k < NUM_SEG - 1; k++) begin
            if (k >= int'(req_seg) && run) begin
                if (link_en[k]) cnt = cnt + 1;
                else            run = 1'b0;
            end
        end
        lo      = int'(req_seg) * SEG_LEN;
        pos_err = (int'(req_seg) >= NUM_SEG) || (int'(req_pos) >= cnt * SEG_LEN);
        span_lo = POS_W'(lo);
        span_hi = POS_W'(lo + cnt * SEG_LEN - 1);
        abs_pos = POS_W'(lo + int'(req_pos));
    end

    // R10: with no links the span is exactly one segment
    p_single_bound_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (link_en == '0) |-> (pos_err == (int'(req_pos) >= SEG_LEN)));

    // R8: an accepted target always lies inside the span
    p_target_inside_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !pos_err |-> (abs_pos >= span_lo && abs_pos <= span_hi));
endmodule

// File: rtl/smem_segment.sv
module smem_segment
    import smem_pkg::*;
#(
    parameter int SEG_IDX = 0,
    parameter int SEG_LEN = 8,
    parameter int DATA_W  = 8,
    parameter int POS_W   = 5
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           act,
    input  op_e                            op,
    input  logic                           dir,
    input  logic [POS_W-1:0]               abs_pos,
    input  logic [POS_W-1:0]               span_lo,
    input  logic [POS_W-1:0]               span_hi,
    input  logic [DATA_W-1:0]              wdata,
    input  logic [DATA_W-1:0]              prev_tail,
    input  logic [DATA_W-1:0]              next_head,
    output logic [SEG_LEN-1:0][DATA_W-1:0] slot_q
);
    localparam int BASE = SEG_IDX * SEG_LEN;

    logic [SEG_LEN-1:0][DATA_W-1:0] slot_d;
    logic [SEG_LEN+1:0][DATA_W-1:0] ext;

    always_comb begin
        ext[0]         = prev_tail;
        ext[SEG_LEN+1] = next_head;
        for (int j = 0; j < SEG_LEN; j++) ext[j+1] = slot_q[j];
    end

    always_comb begin
        slot_d = slot_q;
        if (act) begin
            for (int j = 0; j < SEG_LEN; j++) begin
                int g;
                int p;
                int lo;
                int hi;
                g  = BASE + j;
                p  = int'(abs_pos);
                lo = int'(span_lo);
                hi = int'(span_hi);
                if (g >= lo && g <= hi) begin
                    unique case (op)
                        OP_WRITE: begin
                            if (g == p) slot_d[j] = wdata;
                        end
                        OP_INSERT: begin
                            if (g == p)              slot_d[j] = wdata;
                            else if (!dir && g > p)  slot_d[j] = ext[j];
                            else if (dir && g < p)   slot_d[j] = ext[j+2];
                        end
                        OP_DELETE: begin
                            if (!dir && g >= p)
                                slot_d[j] = (g == hi) ? '0 : ext[j+2];
                            else if (dir && g <= p)
                                slot_d[j] = (g == lo) ? '0 : ext[j];
                        end
                        default: ;
                    endcase
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) slot_q <= '0;
        else        slot_q <= slot_d;
    end

    // R2: idle cycles and reads leave the segment untouched
    p_read_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!act || op == OP_READ) |=> $stable(slot_q));

    // R9: a segment wholly outside the span keeps its contents
    p_outside_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (act && (int'(span_hi) < BASE || int'(span_lo) > BASE + SEG_LEN - 1))
        |=> $stable(slot_q));

    // R8: a tailward insert upstream moves the previous segment's tail into slot 0
    p_relay_carry_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (act && op == OP_INSERT && !dir && int'(span_lo) < BASE &&
         int'(abs_pos) < BASE && BASE <= int'(span_hi))
        |=> (slot_q[0] == $past(prev_tail)));
endmodule

// File: rtl/smem_relay_track.sv
module smem_relay_track
    import smem_pkg::*;
#(
    parameter int NUM_SEG = 4,
    parameter int SEG_LEN = 8,
    parameter int DATA_W  = 8,
    localparam int TOTAL  = NUM_SEG * SEG_LEN,
    localparam int POS_W  = (TOTAL > 1) ? $clog2(TOTAL) : 1,
    localparam int SEG_W  = (NUM_SEG > 1) ? $clog2(NUM_SEG) : 1,
    localparam int LINK_W = (NUM_SEG > 1) ? NUM_SEG - 1 : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [1:0]        req_op,
    input  logic              req_dir,
    input  logic [SEG_W-1:0]  req_seg,
    input  logic [POS_W-1:0]  req_pos,
    input  logic [DATA_W-1:0] req_data,
    input  logic [LINK_W-1:0] link_en,
    output logic              rsp_done,
    output logic              rsp_err,
    output logic [DATA_W-1:0] rsp_data
);
    typedef struct packed {
        logic              done;
        logic              err;
        logic [DATA_W-1:0] data;
    } rsp_t;

    op_e                                         op;
    logic [POS_W-1:0]                            span_lo;
    logic [POS_W-1:0]                            span_hi;
    logic [POS_W-1:0]                            abs_pos;
    logic                                        pos_err;
    logic                                        seg_act;
    logic [NUM_SEG-1:0][SEG_LEN-1:0][DATA_W-1:0] seg_q;
    logic [TOTAL-1:0][DATA_W-1:0]                mem_w;
    rsp_t                                        rsp_d;
    rsp_t                                        rsp_q;

    assign op      = op_e'(req_op);
    assign seg_act = req_valid && !pos_err;
    assign mem_w   = seg_q;

    smem_span #(
        .NUM_SEG (NUM_SEG),
        .SEG_LEN (SEG_LEN)
    ) u_span (
        .clk     (clk),
        .rst_n   (rst_n),
        .req_seg (req_seg),
        .req_pos (req_pos),
        .link_en (link_en),
        .span_lo (span_lo),
        .span_hi (span_hi),
        .abs_pos (abs_pos),
        .pos_err (pos_err)
    );

    for (genvar s = 0; s < NUM_SEG; s++) begin : g_seg
        logic [DATA_W-1:0] prev_tail;
        logic [DATA_W-1:0] next_head;
        if (s == 0) begin : g_first
            assign prev_tail = '0;
        end else begin : g_mid_lo
            assign prev_tail = seg_q[s-1][SEG_LEN-1];
        end
        if (s == NUM_SEG - 1) begin : g_last
            assign next_head = '0;
        end else begin : g_mid_hi
            assign next_head = seg_q[s+1][0];
        end
        smem_segment #(
            .SEG_IDX (s),
            .SEG_LEN (SEG_LEN),
            .DATA_W  (DATA_W),
            .POS_W   (POS_W)
        ) u_segment (
            .clk       (clk),
            .rst_n     (rst_n),
            .act       (seg_act),
            .op        (op),
            .dir       (req_dir),
            .abs_pos   (abs_pos),
            .span_lo   (span_lo),
            .span_hi   (span_hi),
            .wdata     (req_data),
            .prev_tail (prev_tail),
            .next_head (next_head),
            .slot_q    (seg_q[s])
        );
    end

    always_comb begin
        rsp_d = '0;
        if (req_valid) begin
            rsp_d.done = 1'b1;
            rsp_d.err  = pos_err;
            if (!pos_err && op == OP_READ) rsp_d.data = mem_w[abs_pos];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) rsp_q <= '0;
        else        rsp_q <= rsp_d;
    end

    assign rsp_done = rsp_q.done;
    assign rsp_err  = rsp_q.err;
    assign rsp_data = rsp_q.data;

    // R10: a rejection is always reported together with completion
    p_err_with_done_r10: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_err |-> rsp_done);

    // R11: non-read completions carry zero data
    p_quiet_data_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_done && $past(req_op) != 2'd0) |-> (rsp_data == '0));
endmodule

// File: tb/smem_relay_track_tb.sv
`timescale 1ns/1ps
module smem_relay_track_tb;
    localparam int NUM_SEG = 4;
    localparam int SEG_LEN = 8;
    localparam int DATA_W  = 8;
    localparam int TOTAL   = NUM_SEG * SEG_LEN;
    localparam int POS_W   = 5;
    localparam int SEG_W   = 2;
    localparam int LINK_W  = 3;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              req_valid = 1'b0;
    logic [1:0]        req_op = '0;
    logic              req_dir = 1'b0;
    logic [SEG_W-1:0]  req_seg = '0;
    logic [POS_W-1:0]  req_pos = '0;
    logic [DATA_W-1:0] req_data = '0;
    logic [LINK_W-1:0] link_en = '0;
    logic              rsp_done;
    logic              rsp_err;
    logic [DATA_W-1:0] rsp_data;

    int checks = 0;
    int failures = 0;
    logic [DATA_W-1:0] ref_mem [TOTAL];

    always #10 clk = ~clk;

    smem_relay_track #(
        .NUM_SEG (NUM_SEG),
        .SEG_LEN (SEG_LEN),
        .DATA_W  (DATA_W)
    ) u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_op    (req_op),
        .req_dir   (req_dir),
        .req_seg   (req_seg),
        .req_pos   (req_pos),
        .req_data  (req_data),
        .link_en   (link_en),
        .rsp_done  (rsp_done),
        .rsp_err   (rsp_err),
        .rsp_data  (rsp_data)
    );

    task automatic chk(input string tag, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    function automatic int span_len(input int seg, input logic [LINK_W-1:0] links);
        int n = 1;
        for (int k = seg; k < NUM_SEG - 1; k++) begin
            if (!links[k]) break;
            n++;
        end
        return n * SEG_LEN;
    endfunction

    task automatic model_apply(input int op, input int dir, input int seg, input int pos,
                               input int data, input logic [LINK_W-1:0] links);
        int lo = seg * SEG_LEN;
        int hi = lo + span_len(seg, links) - 1;
        int p  = lo + pos;
        case (op)
            1: ref_mem[p] = DATA_W'(data);
            2: begin
                if (dir == 0) for (int i = hi; i > p; i--) ref_mem[i] = ref_mem[i-1];
                else          for (int i = lo; i < p; i++) ref_mem[i] = ref_mem[i+1];
                ref_mem[p] = DATA_W'(data);
            end
            3: begin
                if (dir == 0) begin
                    for (int i = p; i < hi; i++) ref_mem[i] = ref_mem[i+1];
                    ref_mem[hi] = '0;
                end else begin
                    for (int i = p; i > lo; i--) ref_mem[i] = ref_mem[i-1];
                    ref_mem[lo] = '0;
                end
            end
            default: ;
        endcase
    endtask

    task automatic do_op(input int op, input int dir, input int seg, input int pos,
                         input int data, input logic [LINK_W-1:0] links, input string tag);
        bit err;
        int exp_data;
        @(negedge clk);
        chk("R11", "done idle between requests", int'(rsp_done), 0);
        err = pos >= span_len(seg, links);
        exp_data = (!err && op == 0) ? int'(ref_mem[seg * SEG_LEN + pos]) : 0;
        req_valid = 1'b1;
        req_op    = 2'(op);
        req_dir   = dir[0];
        req_seg   = SEG_W'(seg);
        req_pos   = POS_W'(pos);
        req_data  = DATA_W'(data);
        link_en   = links;
        @(negedge clk);
        req_valid = 1'b0;
        chk("R11", "done pulse", int'(rsp_done), 1);
        chk(err ? "R10" : tag, "err flag", int'(rsp_err), int'(err));
        chk(tag, "rsp data", int'(rsp_data), exp_data);
        if (!err) model_apply(op, dir, seg, pos, data, links);
    endtask

    task automatic read_all(input string tag);
        for (int s = 0; s < NUM_SEG; s++)
            for (int j = 0; j < SEG_LEN; j++)
                do_op(0, 0, s, j, 0, '0, tag);
    endtask

    function automatic string tag_of(input int op, input int dir);
        case (op)
            0: return "R2";
            1: return "R3";
            2: return dir ? "R5" : "R4";
            default: return dir ? "R7" : "R6";
        endcase
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired actual=0 expected=1");
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        for (int i = 0; i < TOTAL; i++) ref_mem[i] = '0;
        repeat (4) @(negedge clk);
        chk("R1", "done in reset", int'(rsp_done), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1", "err after reset", int'(rsp_err), 0);
        read_all("R1");

        for (int s = 0; s < NUM_SEG; s++)
            for (int j = 0; j < SEG_LEN; j++)
                do_op(1, 0, s, j, s * 16 + j + 1, '0, "R3");
        read_all("R3");

        do_op(2, 0, 1, 3, 8'hAA, 3'b000, "R4");   // tail of seg1 dropped
        read_all("R9");
        do_op(2, 0, 0, 7, 8'hBB, 3'b011, "R8");   // ripple across seg0..seg2
        read_all("R8");
        do_op(2, 1, 1, 5, 8'hCC, 3'b110, "R5");
        read_all("R5");
        do_op(2, 1, 1, 9, 8'hC1, 3'b110, "R5");   // head side across boundary
        read_all("R8");
        do_op(3, 0, 0, 2, 0, 3'b111, "R6");
        read_all("R6");
        do_op(3, 1, 1, 12, 0, 3'b010, "R7");
        read_all("R7");
        do_op(1, 0, 2, 8, 8'h11, 3'b000, "R10");
        do_op(2, 0, 0, 16, 8'h22, 3'b001, "R10");
        do_op(3, 1, 3, 8, 0, 3'b111, "R10");
        read_all("R10");

        void'($urandom(32'd2024));
        for (int n = 0; n < 400; n++) begin
            int op  = int'($urandom_range(3, 0));
            int dir = int'($urandom_range(1, 0));
            int seg = int'($urandom_range(NUM_SEG - 1, 0));
            logic [LINK_W-1:0] links = LINK_W'($urandom);
            int lim = span_len(seg, links);
            int pos = ($urandom_range(9, 0) == 0) ? int'($urandom_range(TOTAL - 1, 0))
                                                  : int'($urandom_range(lim - 1, 0));
            do_op(op, dir, seg, pos, int'($urandom_range(255, 1)), links, tag_of(op, dir));
            if (n % 50 == 49) read_all("R9");
        end
        read_all("R9");

        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule